// File: doc/BRIEF.md
# Interrupt Status Aggregator with Set/Clear Enable

This block collects single-cycle event pulses from neighbouring program, read and cache engines into a sticky status register and reduces them to one level-sensitive interrupt line. Software acknowledges an event by writing a one to its status bit. Which sources may raise the line is held in an enable mask. Software cannot write this mask directly: it ORs bits in through an enable-set register and removes them through an enable-clear register. Neither of these two registers holds any state.

Only six bit positions carry meaning: bits 4:0 for the five low events and bit 31 for the bus slave error event. The event input vector maps index i (0..4) to status bit i and index 5 to bit 31. Bits 30:5 are reserved in every register. The register port is a simple single-cycle write strobe with a word address and a combinational read port. Address 0 selects status, 1 the mask, 2 enable-set and 3 enable-clear.

Top module: `irq_status_agg`

## Requirements
- R1: While reset is asserted and right after it is released, status reads 0x00000000, the mask reads 0x8000001F and irq is low.
- R2: A pulse on evt_pulse[i] for i in 0..4 sets status bit i, and a pulse on evt_pulse[5] sets status bit 31. The bit stays set after the pulse ends.
- R3: A write to address 0 clears each status bit at 31 or 4:0 where the written data has a one. Status bits written with zero keep their value.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit is set after that edge.
- R5: A write to address 1 (the mask) has no effect on the mask.
- R6: A write to address 2 ORs the written bits 31 and 4:0 into the mask.
- R7: A write to address 3 removes the written bits 31 and 4:0 from the mask.
- R8: Bits 30:5 read as zero at all four addresses, whatever was written. Addresses 2 and 3 read as all zeros.
- R9: irq is high exactly when status AND mask is non-zero. It reflects each write and event from the clock edge that applies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Write word address (0 status, 1 mask, 2 enable-set, 3 enable-clear) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address, same encoding |
| rd_data | output | 32 | Combinational read data |
| evt_pulse | input | 6 | Event pulses; index 5 maps to status bit 31 |
| irq | output | 1 | Level interrupt, registered |

## Verification
An event pulse and a write-one-to-clear can land on the same status bit in the same cycle. The bench provokes this by driving every event together with a clearing write of all valid bits. It then expects every valid status bit still set and irq high. A sweep over all 64 mask and 64 status patterns also applies each event pulse in the cycle right after a clearing write. It judges status, mask and irq against an arithmetic model of the set, clear and enable rules.

// File: rtl/irq_status_agg_pkg.sv
package irq_status_agg_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_ENSET  = 2'd2,
    REG_ENCLR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/isr_evt_map.sv
module isr_evt_map #(
  parameter int DATA_W  = 32,
  parameter int LOW_EVT = 5,
  localparam int NUM_EVT = LOW_EVT + 1
) (
  input  logic [NUM_EVT-1:0] evt,
  output logic [DATA_W-1:0]  bits
);
  // low events land on their own index, the last one on the top bit
  for (genvar i = 0; i < LOW_EVT; i++) begin : g_low
    assign bits[i] = evt[i];
  end
  for (genvar j = LOW_EVT; j < DATA_W-1; j++) begin : g_rsvd
    assign bits[j] = 1'b0;
  end
  assign bits[DATA_W-1] = evt[LOW_EVT];
endmodule

// File: rtl/isr_status_reg.sv
module isr_status_reg #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_bits,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] status_d
);
  logic [DATA_W-1:0] clr_bits;
  logic              upd;

  always_comb begin
    clr_bits = clr_en ? (clr_data & VALID) : '0;
    // clear first, then set: an event in the same cycle wins
    status_d = (status_q & ~clr_bits) | (set_bits & VALID);
    upd      = clr_en | (|set_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_q <= '0;
    else if (upd) status_q <= status_d;
  end

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_bits) |=> ((status_q & $past(set_bits & VALID)) == $past(set_bits & VALID)));

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_bits == '0) |=> ((status_q & $past(clr_data & VALID)) == '0));

  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && |(set_bits & clr_data & VALID)) |=>
      ((status_q & $past(set_bits & clr_data & VALID)) != '0));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] mask_d
);
  logic [DATA_W-1:0] wbits;
  logic              upd;

  always_comb begin
    wbits  = data & VALID;
    mask_d = mask_q;
    if (en_set) mask_d = mask_d | wbits;
    if (en_clr) mask_d = mask_d & ~wbits;
    upd    = en_set | en_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask_q <= VALID;
    else if (upd) mask_q <= mask_d;
  end

  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set && !en_clr) |=> ((mask_q & $past(data & VALID)) == $past(data & VALID)));

  p_mask_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !en_set) |=> ((mask_q & $past(data & VALID)) == '0));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_set && !en_clr) |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_status_agg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LOW_EVT = 5,
  localparam int NUM_EVT = LOW_EVT + 1,
  localparam logic [DATA_W-1:0] VALID =
    {1'b1, {(DATA_W-1-LOW_EVT){1'b0}}, {LOW_EVT{1'b1}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic              irq
);
  logic [DATA_W-1:0] set_bits, status_q, status_d, mask_q, mask_d;
  logic              st_clr, mk_set, mk_clr, irq_d;

  always_comb begin
    st_clr = wr_en && (reg_sel_e'(wr_addr) == REG_STATUS);
    mk_set = wr_en && (reg_sel_e'(wr_addr) == REG_ENSET);
    mk_clr = wr_en && (reg_sel_e'(wr_addr) == REG_ENCLR);
  end

  isr_evt_map #(.DATA_W(DATA_W), .LOW_EVT(LOW_EVT)) u_map (
    .evt  (evt_pulse),
    .bits (set_bits)
  );

  isr_status_reg #(.DATA_W(DATA_W), .VALID(VALID)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (set_bits),
    .clr_en   (st_clr),
    .clr_data (wr_data),
    .status_q (status_q),
    .status_d (status_d)
  );

  isr_mask_reg #(.DATA_W(DATA_W), .VALID(VALID)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_set (mk_set),
    .en_clr (mk_clr),
    .data   (wr_data),
    .mask_q (mask_q),
    .mask_d (mask_d)
  );

  // irq is registered from next-state values so it moves with status and mask
  always_comb irq_d = |(status_d & mask_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      REG_STATUS: rd_data = status_q;
      REG_MASK:   rd_data = mask_q;
      default:    rd_data = '0;
    endcase
  end

  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(status_q & mask_q));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~VALID) == '0);
endmodule

// File: tb/irq_status_agg_tb_top.sv
`timescale 1ns/1ps
module irq_status_agg_tb_top;
  localparam logic [31:0] VLD  = 32'h8000001F;
  localparam logic [31:0] RSVD = 32'h7FFFFFE0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic [5:0]  evt_pulse;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] exp_st, exp_mk;

  always #2.5 clk = ~clk;

  irq_status_agg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  function automatic logic [31:0] spread(input logic [5:0] e);
    return {e[5], 26'b0, e[4:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic chk_all(input string tag);
    logic [31:0] v;
    rd(2'd0, v); chk({tag, " status"}, v, exp_st);
    rd(2'd1, v); chk({tag, " mask"}, v, exp_mk);
    rd(2'd2, v); chk({tag, " R8 enset read"}, v, 32'h0);
    rd(2'd3, v); chk({tag, " R8 enclr read"}, v, 32'h0);
    chk({tag, " R9 irq"}, {31'b0, irq}, {31'b0, |(exp_st & exp_mk)});
  endtask

  // one cycle: drive at negedge, model the edge, return at next negedge
  task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d,
                     input logic [5:0] e);
    wr_en = we; wr_addr = a; wr_data = d; evt_pulse = e;
    if (we && a == 2'd0) exp_st = exp_st & ~(d & VLD);
    exp_st = exp_st | spread(e);
    if (we && a == 2'd2) exp_mk = exp_mk | (d & VLD);
    if (we && a == 2'd3) exp_mk = exp_mk & ~(d & VLD);
    @(negedge clk);
    wr_en = 1'b0; evt_pulse = '0; wr_data = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; evt_pulse = '0;
    exp_st = '0; exp_mk = VLD;
    repeat (3) @(negedge clk);
    chk_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release");

    // R2: each event alone, sticky across an idle cycle
    for (int i = 0; i < 6; i++) begin
      cyc(1'b0, 2'd0, 32'h0, 6'(1 << i));
      chk_all("R2 event");
      cyc(1'b0, 2'd0, 32'h0, 6'h0);
      chk_all("R2 sticky");
      cyc(1'b1, 2'd0, 32'hFFFFFFFF, 6'h0);
      chk_all("R3 clear all");
    end

    // R5: direct mask writes are ignored
    cyc(1'b1, 2'd1, 32'h0, 6'h0);
    chk_all("R5 mask write zero");
    cyc(1'b1, 2'd3, 32'hFFFFFFFF, 6'h0);
    cyc(1'b1, 2'd1, 32'hFFFFFFFF, 6'h0);
    chk_all("R5 mask write ones");
    cyc(1'b1, 2'd2, VLD, 6'h0);

    // R4: event and clear on the same bits in one cycle
    cyc(1'b1, 2'd0, VLD | RSVD, 6'h3F);
    chk_all("R4 event wins");
    // R3: partial clear leaves other bits
    cyc(1'b1, 2'd0, 32'h80000001, 6'h0);
    chk_all("R3 partial clear");
    cyc(1'b1, 2'd0, 32'h0, 6'h0);
    chk_all("R3 zero write");
    cyc(1'b1, 2'd0, 32'hFFFFFFFF, 6'h0);

    // sweep: every mask pattern against every status pattern
    for (int m = 0; m < 64; m++) begin
      for (int s = 0; s < 64; s++) begin
        cyc(1'b1, 2'd3, 32'hFFFFFFFF, 6'h0);
        cyc(1'b1, 2'd2, spread(6'(m)) | RSVD, 6'h0);
        cyc(1'b1, 2'd0, 32'hFFFFFFFF, 6'h0);
        cyc(1'b0, 2'd0, 32'h0, 6'(s));
        chk_all("R6 R8 R9 sweep");
        cyc(1'b1, 2'd3, spread(6'(s)) | RSVD, 6'h0);
        chk_all("R7 R9 partial disable");
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule